// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands a command, along with up to sixteen bytes of payload, to an on-chip management controller. The host can then collect a result. On the host side, reads and writes are single-cycle strobes on a 32-bit data path. A write to the command word starts a transaction. That write raises a one-cycle doorbell toward the controller and sets a busy flag. The busy flag stays set until the controller finishes.

The controller sees the following:

- the decoded opcode, tag and payload length of the accepted command;
- the whole request buffer, as one flat vector.

The controller fills response words through its own write port. It ends the transaction with a done strobe that carries a fail flag and an 8-bit fault code. The host polls status until busy drops. If the accepted command asked for it, the host also receives a single-cycle completion pulse that needs no acknowledgement.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, a read of status (offset 0x04) returns only the initiator field, which is the parameter `INIT_ID` in bits [15:8]. All other status bits read 0, and `ctl_doorbell` and `host_irq` are low.
- R2: A host write to offset 0x00 while idle is accepted. The command word layout is: opcode in [7:0], completion-pulse request in bit 8, tag in [15:12] and length in [23:16]. In the cycle after the write, busy is set, `ctl_doorbell` is high for exactly one cycle, and `ctl_cmd`, `ctl_cmd_id` and `ctl_size` present those fields.
- R3: A host write to offset 0x00 while busy is ignored. It raises no doorbell and leaves the presented fields unchanged.
- R4: Busy stays set until `ctl_done` is asserted and clears in the cycle after it. On that same strobe, the status fail bit takes `ctl_err` and the fault code takes `ctl_err_code`.
- R5: The status layout is: busy in bit 0, fail in bit 1, bits [3:2] zero, the accepted tag in [7:4], `INIT_ID` in [15:8], the fault code in [23:16] and zero in [31:24].
- R6: `host_irq` pulses for exactly one cycle, in the cycle after the finishing done strobe, and only when bit 8 of the accepted command word was 1.
- R7: A host write to offset 0x80+4k (k = 0..3) stores the word in `ctl_req[32k+31:32k]`. Host reads of these offsets return 0.
- R8: A controller write of word k lands at host offset 0x90+4k and can be read there. Host writes to those offsets are ignored.
- R9: Host reads of offset 0x00 and of any unmapped offset return 0.
- R10: A `ctl_done` strobe while idle changes nothing and raises no `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational on `host_addr`) |
| host_irq | output | 1 | One-cycle completion pulse to the host |
| ctl_doorbell | output | 1 | One-cycle new-command pulse to the controller |
| ctl_cmd | output | 8 | Accepted opcode |
| ctl_cmd_id | output | 4 | Accepted tag |
| ctl_size | output | 8 | Accepted payload length in bytes |
| ctl_req | output | 128 | Request buffer, word k in bits [32k+31:32k] |
| ctl_rsp_we | input | 1 | Controller response-word write strobe |
| ctl_rsp_idx | input | 2 | Response word index |
| ctl_rsp_wdata | input | 32 | Response word data |
| ctl_done | input | 1 | Controller completion strobe |
| ctl_err | input | 1 | Fail flag, sampled with `ctl_done` |
| ctl_err_code | input | 8 | Fault code, sampled with `ctl_done` |

## Verification
The hardest situation to reach from the ports is a second command-word write that arrives during an open transaction. The bench must show that this write leaves no trace, even though the same write would start a transaction a cycle earlier. The bench first issues a command, then, while busy is still set, writes a command word with a different opcode, tag and length. It then confirms that no doorbell follows and that the presented fields and the echoed tag still hold the first command. A done strobe given while idle is checked the same way, by reading back status and watching for the completion pulse.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int          BUF_WORDS = 4,
  parameter logic [7:0]  INIT_ID   = 8'h5A,
  parameter logic [7:0]  CMD_OFS   = 8'h00,
  parameter logic [7:0]  STAT_OFS  = 8'h04,
  parameter logic [7:0]  REQ_OFS   = 8'h80,
  parameter logic [7:0]  RSP_OFS   = 8'h90
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_wr,
  input  logic [7:0]                    host_addr,
  input  logic [31:0]                   host_wdata,
  output logic [31:0]                   host_rdata,
  output logic                          host_irq,
  output logic                          ctl_doorbell,
  output logic [7:0]                    ctl_cmd,
  output logic [3:0]                    ctl_cmd_id,
  output logic [7:0]                    ctl_size,
  output logic [32*BUF_WORDS-1:0]       ctl_req,
  input  logic                          ctl_rsp_we,
  input  logic [$clog2(BUF_WORDS)-1:0]  ctl_rsp_idx,
  input  logic [31:0]                   ctl_rsp_wdata,
  input  logic                          ctl_done,
  input  logic                          ctl_err,
  input  logic [7:0]                    ctl_err_code
);
  localparam int IW = $clog2(BUF_WORDS);
  localparam logic [7:0] SPAN = 8'(4 * BUF_WORDS);

  logic        busy_q, err_q, ioc_q, bell_q, irq_q;
  logic [7:0]  op_q, len_q, code_q;
  logic [3:0]  tag_q;
  logic [31:0] req_q [BUF_WORDS];
  logic [31:0] rsp_q [BUF_WORDS];

  logic [7:0] req_off, rsp_off;
  logic       req_hit, rsp_hit, cmd_take, fin;
  logic [IW-1:0] req_idx, rsp_idx;

  assign req_off  = host_addr - REQ_OFS;
  assign rsp_off  = host_addr - RSP_OFS;
  assign req_hit  = (req_off < SPAN) && (host_addr[1:0] == 2'b00);
  assign rsp_hit  = (rsp_off < SPAN) && (host_addr[1:0] == 2'b00);
  assign req_idx  = req_off[IW+1:2];
  assign rsp_idx  = rsp_off[IW+1:2];
  assign cmd_take = host_wr && (host_addr == CMD_OFS) && !busy_q;
  assign fin      = ctl_done && busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      ioc_q  <= 1'b0;
      bell_q <= 1'b0;
      irq_q  <= 1'b0;
      op_q   <= '0;
      len_q  <= '0;
      tag_q  <= '0;
      code_q <= '0;
    end else begin
      bell_q <= cmd_take;
      irq_q  <= fin && ioc_q;
      if (cmd_take) begin
        busy_q <= 1'b1;
        op_q   <= host_wdata[7:0];
        ioc_q  <= host_wdata[8];
        tag_q  <= host_wdata[15:12];
        len_q  <= host_wdata[23:16];
      end else if (fin) begin
        busy_q <= 1'b0;
        err_q  <= ctl_err;
        code_q <= ctl_err_code;
      end
    end
  end

  for (genvar k = 0; k < BUF_WORDS; k++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_q[k] <= '0;
        rsp_q[k] <= '0;
      end else begin
        if (host_wr && req_hit && req_idx == IW'(k)) req_q[k] <= host_wdata;
        if (ctl_rsp_we && ctl_rsp_idx == IW'(k))     rsp_q[k] <= ctl_rsp_wdata;
      end
    end
    assign ctl_req[32*k +: 32] = req_q[k];
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == STAT_OFS)
      host_rdata = {8'h00, code_q, INIT_ID, tag_q, 2'b00, err_q, busy_q};
    else if (rsp_hit)
      host_rdata = rsp_q[rsp_idx];
  end

  assign host_irq     = irq_q;
  assign ctl_doorbell = bell_q;
  assign ctl_cmd      = op_q;
  assign ctl_cmd_id   = tag_q;
  assign ctl_size     = len_q;
endmodule

// File: rtl/ipc_mailbox_sva.sv
module ipc_mailbox_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [7:0] host_addr,
  input logic       busy_q,
  input logic       ioc_q,
  input logic       ctl_done,
  input logic       ctl_doorbell,
  input logic       host_irq
);
  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 8'h00 && !busy_q) |=> (busy_q && ctl_doorbell));

  a_r3_no_second_bell: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 8'h00 && busy_q) |=> !ctl_doorbell);

  a_r4_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ctl_done) |=> busy_q);

  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ctl_done) |=> !busy_q);

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ctl_done && ioc_q) |=> host_irq);

  a_r10_idle_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && ctl_done) |=> !host_irq);
endmodule

bind ipc_mailbox ipc_mailbox_sva u_sva (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .busy_q(busy_q), .ioc_q(ioc_q), .ctl_done(ctl_done),
  .ctl_doorbell(ctl_doorbell), .host_irq(host_irq)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  localparam logic [7:0] ID = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [7:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic host_irq, ctl_doorbell;
  logic [7:0] ctl_cmd, ctl_size;
  logic [3:0] ctl_cmd_id;
  logic [127:0] ctl_req;
  logic ctl_rsp_we = 1'b0;
  logic [1:0] ctl_rsp_idx = '0;
  logic [31:0] ctl_rsp_wdata = '0;
  logic ctl_done = 1'b0, ctl_err = 1'b0;
  logic [7:0] ctl_err_code = '0;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .ctl_doorbell(ctl_doorbell), .ctl_cmd(ctl_cmd), .ctl_cmd_id(ctl_cmd_id),
    .ctl_size(ctl_size), .ctl_req(ctl_req), .ctl_rsp_we(ctl_rsp_we),
    .ctl_rsp_idx(ctl_rsp_idx), .ctl_rsp_wdata(ctl_rsp_wdata),
    .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic cdone(logic e, logic [7:0] c);
    ctl_done = 1'b1; ctl_err = e; ctl_err_code = c;
    @(negedge clk);
    ctl_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    hread(8'h04, d);
    chk("R1 status", d, {16'h0, ID, 8'h00});
    chk("R1 doorbell", {31'b0, ctl_doorbell}, 0);
    chk("R1 irq", {31'b0, host_irq}, 0);
  endtask

  task automatic t_request;
    logic [31:0] d;
    for (int k = 0; k < 4; k++) hwrite(8'h80 + 8'(4*k), 32'h1111_0000 + 32'(k));
    for (int k = 0; k < 4; k++) chk("R7 req word", ctl_req[32*k +: 32], 32'h1111_0000 + 32'(k));
    hread(8'h84, d);
    chk("R7 req read zero", d, 0);
  endtask

  task automatic t_cmd_ioc;
    logic [31:0] d;
    hwrite(8'h00, 32'h000C_31A7);
    chk("R2 doorbell", {31'b0, ctl_doorbell}, 1);
    chk("R2 fields", {12'h0, ctl_cmd, ctl_cmd_id, ctl_size}, {12'h0, 8'hA7, 4'h3, 8'h0C});
    hread(8'h04, d);
    chk("R5 status busy", d, {16'h0, ID, 8'h31});
    @(negedge clk);
    chk("R2 doorbell one cycle", {31'b0, ctl_doorbell}, 0);
    hwrite(8'h00, 32'h0004_5155);
    chk("R3 no doorbell", {31'b0, ctl_doorbell}, 0);
    chk("R3 fields kept", {12'h0, ctl_cmd, ctl_cmd_id, ctl_size}, {12'h0, 8'hA7, 4'h3, 8'h0C});
    repeat (3) @(negedge clk);
    hread(8'h04, d);
    chk("R4 still busy", d, {16'h0, ID, 8'h31});
    ctl_rsp_we = 1'b1; ctl_rsp_idx = 2'd2; ctl_rsp_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    ctl_rsp_we = 1'b0;
    cdone(1'b0, 8'h00);
    chk("R6 irq", {31'b0, host_irq}, 1);
    hread(8'h04, d);
    chk("R4 busy cleared", d, {16'h0, ID, 8'h30});
    @(negedge clk);
    chk("R6 irq one cycle", {31'b0, host_irq}, 0);
    hread(8'h98, d);
    chk("R8 rsp read", d, 32'hCAFE_F00D);
    hwrite(8'h98, 32'h0);
    hread(8'h98, d);
    chk("R8 host write ignored", d, 32'hCAFE_F00D);
  endtask

  task automatic t_cmd_err;
    logic [31:0] d;
    hwrite(8'h00, 32'h0010_9012);
    chk("R2 doorbell 2", {31'b0, ctl_doorbell}, 1);
    @(negedge clk);
    cdone(1'b1, 8'h42);
    chk("R6 no irq", {31'b0, host_irq}, 0);
    hread(8'h04, d);
    chk("R4 R5 fail status", d, {8'h00, 8'h42, ID, 8'h92});
    @(negedge clk);
    chk("R6 no irq later", {31'b0, host_irq}, 0);
  endtask

  task automatic t_idle_done;
    logic [31:0] d;
    cdone(1'b0, 8'h77);
    chk("R10 no irq", {31'b0, host_irq}, 0);
    hread(8'h04, d);
    chk("R10 status kept", d, {8'h00, 8'h42, ID, 8'h92});
  endtask

  task automatic t_zero_reads;
    logic [31:0] d;
    hread(8'h00, d);
    chk("R9 cmd read", d, 0);
    hread(8'h40, d);
    chk("R9 unmapped", d, 0);
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_request();
    t_cmd_ioc();
    t_cmd_err();
    t_idle_done();
    t_zero_reads();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule